// File: doc/BRIEF.md
# Serial Memory Slave Controller

This block is a synchronous serial slave that fronts a byte-wide memory array. A host drives a serial clock, an active-low select, a data input and an active-low pause input. The block oversamples all four pins with a much faster system clock. It decodes an 8-bit command, gathers a 16-bit address, then streams data bytes into or out of the array. Bytes travel most significant bit first. Input bits are taken on the rising serial-clock edge, and output bits change on the falling edge. Both clock polarities that share this rule are accepted: idle low (mode 0) and idle high (mode 3). Bursts step the address by one per byte and wrap from the top of the 15-bit space back to zero.

Write permission lives in a separate protection unit. The block sends that unit pulses when the write-enable latch is to be set or cleared, and a pulse with a byte when the status byte is to be written. It shows the unit the address that is about to be written and drops the write if the unit flags that address. The array depth is a parameter. With the default depth, the upper address bits alias onto the stored range.

Top module: `spi_mem_slave`

## Requirements
- R1: While `cs_n_i` is high, `so_oe_o` is 0 and no command pulse is issued. Reset leaves the block in this idle state.
- R2: In mode 0 and in mode 3, SI is captured on the rising SCK edge and SO is updated on the falling SCK edge, MSB first.
- R3: Command 0x06 gives a single-cycle `wen_set_o` pulse. Command 0x04 gives a single-cycle `wen_clr_o` pulse. Both occur as the eighth command bit is taken.
- R4: If select is released before eight command bits have arrived, nothing happens: no pulse, no array write.
- R5: Command 0x01 takes the next byte, pulses `stat_wr_o` once and presents that byte on `stat_wdata_o`. Any later bytes in the same selection are ignored.
- R6: Command 0x05 returns `stat_rd_i` on SO. Each further 8 clocks return the status byte again, for as long as select stays low.
- R7: Command 0x03 takes a 16-bit address whose top bit is ignored. It then returns the byte at that address, followed by one byte per 8 clocks from the next address.
- R8: Command 0x02 takes the same address and commits each complete 8-bit group to successive addresses. A partial final group is discarded.
- R9: The burst address steps from 0x7FFF to 0x0000 in both reads and writes.
- R10: A byte whose target address has `prot_block_i` high is not written, but the address still advances.
- R11: While the pause input is low under select, SO is released and SCK and SI are ignored. The transfer resumes where it stopped. Pause entry and exit take effect only while SCK is low.
- R12: Releasing select during a pause aborts the command and discards a partial byte. The next selection starts a fresh command.
- R13: An unknown command code is ignored until select is released. SO stays released and no pulse is issued.
- R14: Releasing select after a write-memory or write-status command that completed at least one data byte gives one `wen_clr_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from host |
| cs_n_i | input | 1 | Active-low select |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; 0 means high impedance |
| wen_set_o | output | 1 | Pulse: set write-enable latch |
| wen_clr_o | output | 1 | Pulse: clear write-enable latch |
| stat_wr_o | output | 1 | Pulse: write status byte |
| stat_wdata_o | output | 8 | Status byte to write |
| stat_rd_i | input | 8 | Current status byte from the protection unit |
| prot_addr_o | output | 15 | Address of the current burst position |
| prot_block_i | input | 1 | Protection unit flags `prot_addr_o` as protected |

## Verification
A bit counter that slips by even one position shows up on SO within the next returned byte, as a shifted pattern. It also shows as a data byte committed one clock early, which the following read exposes. A stale phase or command register appears at the first byte after an aborted or paused transfer, either as a missing pulse or as data landing at the wrong address. Address-counter faults show at the wrap boundary and at the protection limit, where expected bytes either change or fail to change on the read-back.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int SYNC_DEPTH = 2;

    localparam logic [7:0] OP_SET_WE  = 8'h06;
    localparam logic [7:0] OP_CLR_WE  = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_MEM  = 8'h03;
    localparam logic [7:0] OP_WR_MEM  = 8'h02;

    typedef enum logic [2:0] {
        PH_OPCODE, PH_ADDR_HI, PH_ADDR_LO, PH_DATA, PH_IDLE
    } phase_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_SET_WE, CMD_CLR_WE, CMD_RD_STAT,
        CMD_WR_STAT, CMD_RD_MEM, CMD_WR_MEM
    } cmd_t;

    // Conditioned pin events in the system clock domain
    typedef struct packed {
        logic sel;    // select active
        logic rise;   // qualified rising SCK edge
        logic fall;   // qualified falling SCK edge
        logic si;     // synchronized data in
        logic hold;   // pause in effect
        logic desel;  // select just released
    } spi_evt_t;

    function automatic cmd_t decode_op(input logic [7:0] op);
        case (op)
            OP_SET_WE:  return CMD_SET_WE;
            OP_CLR_WE:  return CMD_CLR_WE;
            OP_RD_STAT: return CMD_RD_STAT;
            OP_WR_STAT: return CMD_WR_STAT;
            OP_RD_MEM:  return CMD_RD_MEM;
            OP_WR_MEM:  return CMD_WR_MEM;
            default:    return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_mem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_i,
    input  logic     cs_n_i,
    input  logic     si_i,
    input  logic     hold_n_i,
    output spi_evt_t ev
);
    logic [SYNC_DEPTH-1:0] sck_r, cs_r, si_r, hold_r;
    logic sck_d, sel_d, hold_q;
    logic sck_s, sel_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_r  <= '0;
            cs_r   <= '1;
            si_r   <= '0;
            hold_r <= '1;
        end else begin
            sck_r  <= {sck_r[SYNC_DEPTH-2:0], sck_i};
            cs_r   <= {cs_r[SYNC_DEPTH-2:0], cs_n_i};
            si_r   <= {si_r[SYNC_DEPTH-2:0], si_i};
            hold_r <= {hold_r[SYNC_DEPTH-2:0], hold_n_i};
        end
    end

    assign sck_s = sck_r[SYNC_DEPTH-1];
    assign sel_s = !cs_r[SYNC_DEPTH-1];

    // Pause state only moves while SCK is low
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            sel_d  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            sck_d <= sck_s;
            sel_d <= sel_s;
            if (!sel_s)
                hold_q <= 1'b0;
            else if (!sck_s)
                hold_q <= !hold_r[SYNC_DEPTH-1];
        end
    end

    always_comb begin
        ev.sel   = sel_s;
        ev.rise  = sel_s && !hold_q && sck_s && !sck_d;
        ev.fall  = sel_s && !hold_q && !sck_s && sck_d;
        ev.si    = si_r[SYNC_DEPTH-1];
        ev.hold  = hold_q;
        ev.desel = !sel_s && sel_d;
    end

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W = 15,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << MEM_AW;
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[addr[MEM_AW-1:0]] <= wdata;
    end

    assign rdata = cells[addr[MEM_AW-1:0]];

endmodule

// File: rtl/spi_mem_seq.sv
module spi_mem_seq
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          ev,
    input  logic [7:0]        stat_rd_i,
    input  logic [7:0]        mem_rdata,
    input  logic              prot_block_i,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              so_bit,
    output logic              so_en,
    output logic              wen_set,
    output logic              wen_clr,
    output logic              stat_wr,
    output logic [7:0]        stat_wdata
);
    localparam int HI_W = ADDR_W - 8;

    phase_t            phase;
    cmd_t              cmd;
    logic [2:0]        bitcnt;
    logic [6:0]        rx;
    logic [7:0]        tx;
    logic [ADDR_W-1:0] addr;
    logic              out_on, load_pend, wrote;
    logic [7:0]        byte_in;
    logic              byte_done;
    cmd_t              op_cmd;

    assign byte_in   = {rx, ev.si};
    assign byte_done = ev.rise && (bitcnt == 3'd7);
    assign op_cmd    = decode_op(byte_in);

    assign mem_addr  = addr;
    assign mem_wdata = byte_in;
    assign mem_we    = byte_done && phase == PH_DATA && cmd == CMD_WR_MEM && !prot_block_i;
    assign so_en     = out_on && ev.sel && !ev.hold;

    always_ff @(posedge clk) begin
        if (rst || !ev.sel) begin
            phase     <= PH_OPCODE;
            cmd       <= CMD_NONE;
            bitcnt    <= '0;
            out_on    <= 1'b0;
            load_pend <= 1'b0;
            wrote     <= 1'b0;
            wen_set   <= 1'b0;
            stat_wr   <= 1'b0;
            wen_clr   <= !rst && ev.desel && wrote;
            if (rst) begin
                rx         <= '0;
                tx         <= '0;
                addr       <= '0;
                so_bit     <= 1'b0;
                stat_wdata <= '0;
            end
        end else begin
            wen_set <= 1'b0;
            wen_clr <= 1'b0;
            stat_wr <= 1'b0;
            if (load_pend) begin
                load_pend <= 1'b0;
                tx <= (cmd == CMD_RD_STAT) ? stat_rd_i : mem_rdata;
                if (cmd == CMD_RD_MEM)
                    addr <= addr + 1'b1;
            end
            if (ev.rise) begin
                rx     <= byte_in[6:0];
                bitcnt <= bitcnt + 3'd1;
            end
            if (byte_done) begin
                case (phase)
                    PH_OPCODE: begin
                        cmd <= op_cmd;
                        case (op_cmd)
                            CMD_SET_WE: begin wen_set <= 1'b1; phase <= PH_IDLE; end
                            CMD_CLR_WE: begin wen_clr <= 1'b1; phase <= PH_IDLE; end
                            CMD_RD_STAT: begin
                                load_pend <= 1'b1;
                                out_on    <= 1'b1;
                                phase     <= PH_DATA;
                            end
                            CMD_WR_STAT: phase <= PH_DATA;
                            CMD_RD_MEM, CMD_WR_MEM: phase <= PH_ADDR_HI;
                            default: phase <= PH_IDLE;
                        endcase
                    end
                    PH_ADDR_HI: begin
                        addr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
                        phase <= PH_ADDR_LO;
                    end
                    PH_ADDR_LO: begin
                        addr[7:0] <= byte_in;
                        phase     <= PH_DATA;
                        if (cmd == CMD_RD_MEM) begin
                            load_pend <= 1'b1;
                            out_on    <= 1'b1;
                        end
                    end
                    PH_DATA: begin
                        case (cmd)
                            CMD_WR_STAT: begin
                                stat_wr    <= 1'b1;
                                stat_wdata <= byte_in;
                                wrote      <= 1'b1;
                                phase      <= PH_IDLE;
                            end
                            CMD_WR_MEM: begin
                                wrote <= 1'b1;
                                addr  <= addr + 1'b1;
                            end
                            default: load_pend <= 1'b1;
                        endcase
                    end
                    default: ;
                endcase
            end
            if (ev.fall && out_on) begin
                so_bit <= tx[7];
                tx     <= {tx[6:0], 1'b0};
            end
        end
    end

    assert_wr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (byte_done && ev.sel && phase == PH_DATA && cmd == CMD_WR_MEM)
        |=> (addr == $past(addr) + 1'b1));

    assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wen_set, wen_clr, stat_wr}));

    assert_stat_wr_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> (cmd == CMD_WR_STAT && phase == PH_IDLE));

    assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (ev.hold && $past(ev.hold) && $past(ev.sel)) |-> ($stable(bitcnt) && $stable(phase)));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              wen_set_o,
    output logic              wen_clr_o,
    output logic              stat_wr_o,
    output logic [7:0]        stat_wdata_o,
    input  logic [7:0]        stat_rd_i,
    output logic [ADDR_W-1:0] prot_addr_o,
    input  logic              prot_block_i
);
    spi_evt_t          ev;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              so_bit;

    spi_pin_sync u_sync (
        .clk(clk), .rst(rst), .sck_i(sck_i), .cs_n_i(cs_n_i),
        .si_i(si_i), .hold_n_i(hold_n_i), .ev(ev)
    );

    spi_mem_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .ev(ev), .stat_rd_i(stat_rd_i),
        .mem_rdata(mem_rdata), .prot_block_i(prot_block_i),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .so_bit(so_bit), .so_en(so_oe_o), .wen_set(wen_set_o),
        .wen_clr(wen_clr_o), .stat_wr(stat_wr_o), .stat_wdata(stat_wdata_o)
    );

    spi_mem_array #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_array (
        .clk(clk), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assign so_o        = so_oe_o ? so_bit : 1'b0;
    assign prot_addr_o = mem_addr;

    // Pin-level view: select high long enough to cross the synchronizer
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3))
        |-> (!so_oe_o && !wen_set_o && !stat_wr_o));

    assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !mem_we);

endmodule

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
    localparam int H = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, wen_set, wen_clr, stat_wr, prot_block;
    logic [7:0] stat_wdata, stat_rd = 8'hA5;
    logic [14:0] prot_addr;
    logic [15:0] lim = 16'h8000;
    logic mode3 = 1'b0;

    int n_chk = 0, n_fail = 0;
    int cnt_set = 0, cnt_clr = 0, cnt_swr = 0, cs_hi = 0;
    bit finished = 0;
    logic [7:0] model [int];
    logic [7:0] wbuf [4];

    always #2.5 clk = ~clk;

    assign prot_block = ({1'b0, prot_addr} >= lim);

    spi_mem_slave uut (
        .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .hold_n_i(hold_n), .so_o(so), .so_oe_o(so_oe), .wen_set_o(wen_set),
        .wen_clr_o(wen_clr), .stat_wr_o(stat_wr), .stat_wdata_o(stat_wdata),
        .stat_rd_i(stat_rd), .prot_addr_o(prot_addr), .prot_block_i(prot_block)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock reference: idle select keeps SO released (R1)
    always @(negedge clk) begin
        if (!rst) begin
            cs_hi = cs_n ? cs_hi + 1 : 0;
            if (cs_hi >= 4) chk("R1 idle so_oe", so_oe, 0);
        end
    end
    always @(posedge clk) begin
        if (wen_set) cnt_set++;
        if (wen_clr) cnt_clr++;
        if (stat_wr) cnt_swr++;
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin(input logic m3);
        mode3 = m3; sck = m3; waitn(H); cs_n = 1'b0; waitn(H);
    endtask

    task automatic cs_end();
        waitn(H); cs_n = 1'b1; waitn(3 * H);
    endtask

    task automatic xbit(input logic b, output logic r);
        if (mode3) sck = 1'b0;
        si = b;
        waitn(H);
        r = so;
        sck = 1'b1;
        waitn(H);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            xbit(t[i], b);
            r[i] = b;
        end
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic m3);
        logic [7:0] r;
        int ad;
        cs_begin(m3);
        xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        ad = a & 16'h7FFF;
        for (int i = 0; i < n; i++) begin
            xbyte(wbuf[i], r);
            if (ad < lim) model[ad] = wbuf[i];
            ad = (ad + 1) & 16'h7FFF;
        end
        cs_end();
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input logic m3, input string req);
        logic [7:0] r;
        int ad;
        cs_begin(m3);
        xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        ad = a & 16'h7FFF;
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            chk(req, r, model[ad]);
            ad = (ad + 1) & 16'h7FFF;
        end
        cs_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic b;
        int s0, c0, w0;
        waitn(8); rst = 1'b0; waitn(4);

        // R1: reset state
        chk("R1 reset so_oe", so_oe, 0);
        chk("R1 reset pulses", {wen_set, wen_clr, stat_wr}, 0);

        // R3 / R2: set and clear commands in both modes
        cs_begin(0); xbyte(8'h06, r); cs_end();
        chk("R3 set pulse mode0", cnt_set, 1);
        cs_begin(1); xbyte(8'h04, r); cs_end();
        chk("R3 R2 clear pulse mode3", cnt_clr, 1);

        // R4: partial command
        cs_begin(0);
        for (int i = 7; i >= 3; i--) xbit(OP6(i), b);
        cs_end();
        chk("R4 partial no set", cnt_set, 1);

        // R5 / R14: status write, second byte ignored, clear on release
        cs_begin(0); xbyte(8'h01, r); xbyte(8'h8C, r); xbyte(8'hFF, r); cs_end();
        chk("R5 stat_wr count", cnt_swr, 1);
        chk("R5 stat data", stat_wdata, 8'h8C);
        chk("R14 clear after stat write", cnt_clr, 2);

        // R6 / R2: status read repeats in mode 3
        cs_begin(1); xbyte(8'h05, r);
        for (int i = 0; i < 3; i++) begin
            xbyte(8'h00, r);
            chk("R6 R2 status byte", r, 8'hA5);
        end
        cs_end();

        // R8 / R7 / R14: burst write with top address bit set, read back
        c0 = cnt_clr;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(16'h8010, 3, 0);
        chk("R14 clear after mem write", cnt_clr, c0 + 1);
        do_read(16'h0010, 3, 0, "R7 R8 readback mode0");
        do_read(16'h8011, 2, 1, "R7 top bit ignored mode3");

        // R8: partial trailing byte discarded
        wbuf[0] = 8'h99; wbuf[1] = 8'h55;
        do_write(16'h0020, 2, 0);
        cs_begin(0);
        xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h20, r); xbyte(8'h44, r);
        for (int i = 0; i < 4; i++) xbit(1'b1, b);
        cs_end();
        model[32'h20] = 8'h44;
        do_read(16'h0020, 2, 0, "R8 partial byte dropped");

        // R9: wrap at the top of the address space
        wbuf[0] = 8'hAB; wbuf[1] = 8'hCD;
        do_write(16'h7FFF, 2, 1);
        do_read(16'hFFFF, 2, 0, "R9 wrap");

        // R10: protection stops writes but address advances
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        do_write(16'h0100, 2, 0);
        lim = 16'h0100;
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        do_write(16'h00FE, 4, 0);
        lim = 16'h8000;
        do_read(16'h00FE, 4, 1, "R10 protected");

        // R13: unknown command
        s0 = cnt_set; c0 = cnt_clr; w0 = cnt_swr;
        cs_begin(0); xbyte(8'h9A, r);
        for (int i = 0; i < 8; i++) begin
            xbit(1'b1, b);
            chk("R13 so_oe stays low", so_oe, 0);
        end
        cs_end();
        chk("R13 no pulses", {cnt_set - s0, cnt_clr - c0, cnt_swr - w0}, 0);

        // R11: pause mid-byte during a read
        cs_begin(0);
        xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h10, r);
        for (int i = 7; i >= 5; i--) begin xbit(1'b0, b); r[i] = b; end
        hold_n = 1'b0; waitn(H);
        chk("R11 so released in pause", so_oe, 0);
        for (int i = 0; i < 2; i++) begin
            si = ~si; sck = 1'b1; waitn(H); sck = 1'b0; waitn(H);
        end
        chk("R11 still released", so_oe, 0);
        hold_n = 1'b1; waitn(H);
        for (int i = 4; i >= 0; i--) begin xbit(1'b0, b); r[i] = b; end
        chk("R11 resumed byte", r, 8'h11);
        xbyte(8'h00, r);
        chk("R11 next byte", r, 8'h22);
        cs_end();

        // R12: release select during pause aborts
        wbuf[0] = 8'h00; wbuf[1] = 8'h66;
        do_write(16'h0030, 2, 0);
        cs_begin(0);
        xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h30, r); xbyte(8'h5A, r);
        for (int i = 0; i < 3; i++) xbit(1'b1, b);
        hold_n = 1'b0; waitn(H);
        cs_n = 1'b1; waitn(H); hold_n = 1'b1; waitn(3 * H);
        model[32'h30] = 8'h5A;
        do_read(16'h0030, 2, 0, "R12 abort in pause");
        s0 = cnt_set;
        cs_begin(1); xbyte(8'h06, r); cs_end();
        chk("R12 fresh command after abort", cnt_set, s0 + 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic OP6(input int i);
        logic [7:0] v = 8'h06;
        return v[i];
    endfunction

endmodule